// File: doc/BRIEF.md
# Latency-Slotted Result Retire Queue

This block sits between the arithmetic units of a small in-order microcoded processor and its register file. Operations take different numbers of steps to finish. Instead of tracking each result's destination, the block keeps a short ring of result slots. When an instruction issues, its result is parked in the slot that the head pointer will reach exactly when that result is due. On the same step the head slot is popped, and its value goes to the register named by the destination field of the instruction issuing now. The microcode scheduler must therefore write each instruction's destination field for the result that matures under it, not for its own result.

Each instruction is one step, marked by a one-cycle strobe. An idle step (no-op class) still pops and advances but parks nothing. A vector-output step freezes the ring completely. The register-file write port is combinational from the current step's inputs and the head slot, so the register file captures the value on the same clock edge that updates the ring.

Top module: `wbq_retire_queue`

## Requirements
- R1: Synchronous reset clears every slot to zero and sets the head to slot 0, so every pop after reset yields zero until a new result is parked.
- R2: While the step strobe is low, the write enable is low and no slot or the head changes, whatever the other inputs carry.
- R3: On a step whose class is not vector-output (class code 2'b10) and whose destination index is nonzero, the write enable is high in that cycle, the write address equals the destination index and the write data equals the value in the head slot.
- R4: A destination index of zero gives no write, but the pop, clear and head advance still take place.
- R5: Every step other than vector-output clears the head slot and advances the head by one, wrapping from slot SLOTS-1 (6 by default) to slot 0.
- R6: A step of an operating class (code 2'b01 or 2'b11) parks its result at slot (head + latency) mod SLOTS, where head is the value before the step. The result therefore appears at the write port on the latency-th following step that is not vector-output. A latency of 0 behaves as SLOTS.
- R7: A no-op step (class code 2'b00) parks nothing. Slots other than the popped one keep their values.
- R8: A vector-output step writes nothing, pops nothing, does not move the head and parks nothing.
- R9: When two results are parked in the same slot, the later one replaces the earlier one.
- R10: A result with latency SLOTS lands in the slot that the same step cleared, and the park wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | One-cycle strobe marking an instruction step |
| cls_i | input | 2 | Step class: 00 no-op, 01/11 operating, 10 vector-output |
| result_i | input | DATA_W | Result produced by the current operation |
| lat_i | input | LAT_W | Latency of the current operation in steps (1..SLOTS) |
| dest_i | input | IDX_W | Destination for the result maturing now; 0 means none |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | IDX_W | Register-file write address |
| rf_wdata_o | output | DATA_W | Register-file write data |

## Verification
A wrong head pointer does not show at once. It shows as wrong data at the write port on the next step that names a destination. It also shifts every later parked result by one or more steps, so the error repeats on each retire that follows. A missing clear, or a park into the wrong slot, shows only when the head next reaches that slot, at most SLOTS steps later. A comparison on every cycle against a model of the ring therefore catches such faults within one lap of the ring. A vector step that leaks an advance shows on the very next pop.

// File: rtl/wbq_pkg.sv
package wbq_pkg;

    typedef enum logic [1:0] {
        CLS_NOP  = 2'b00,
        CLS_OP   = 2'b01,
        CLS_VEC  = 2'b10,
        CLS_OP_B = 2'b11
    } step_cls_e;

    // Sum of a ring index (< n) and an offset (<= n), folded back into 0..n-1.
    function automatic int unsigned ring_add(int unsigned a, int unsigned b, int unsigned n);
        int unsigned s;
        s = a + b;
        if (s >= n) s = s - n;
        if (s >= n) s = s - n;
        return s;
    endfunction

    function automatic logic cls_parks(step_cls_e c);
        return (c == CLS_OP) || (c == CLS_OP_B);
    endfunction

endpackage

// File: rtl/wbq_head_ptr.sv
module wbq_head_ptr #(
    parameter int SLOTS = 7,
    localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_i,
    output logic [PTR_W-1:0] head_o
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(SLOTS - 1);

    logic [PTR_W-1:0] head_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
        end else if (adv_i) begin
            head_q <= (head_q == LAST) ? '0 : head_q + 1'b1;
        end
    end

    assign head_o = head_q;

    a_r5_head_in_range: assert property (@(posedge clk) disable iff (rst)
        head_q <= LAST);

    a_r5_head_advances: assert property (@(posedge clk) disable iff (rst)
        adv_i |=> (head_q == (($past(head_q) == LAST) ? '0 : $past(head_q) + 1'b1)));

    a_r8_head_held: assert property (@(posedge clk) disable iff (rst)
        !adv_i |=> $stable(head_q));

endmodule

// File: rtl/wbq_slot_ring.sv
module wbq_slot_ring #(
    parameter int DATA_W = 32,
    parameter int SLOTS  = 7,
    localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PTR_W-1:0]  rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              clr_en_i,
    input  logic [PTR_W-1:0]  clr_idx_i,
    input  logic              ins_en_i,
    input  logic [PTR_W-1:0]  ins_idx_i,
    input  logic [DATA_W-1:0] ins_data_i
);
    logic [DATA_W-1:0] slot_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        localparam logic [PTR_W-1:0] IDX = PTR_W'(g);
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= '0;
            end else if (ins_en_i && ins_idx_i == IDX) begin
                slot_q[g] <= ins_data_i;   // park beats clear (R10)
            end else if (clr_en_i && clr_idx_i == IDX) begin
                slot_q[g] <= '0;
            end
        end
    end

    assign rd_data_o = slot_q[rd_idx_i];

    a_r10_park_lands: assert property (@(posedge clk) disable iff (rst)
        ins_en_i |=> (slot_q[$past(ins_idx_i)] == $past(ins_data_i)));

    a_r5_pop_clears: assert property (@(posedge clk) disable iff (rst)
        (clr_en_i && !(ins_en_i && ins_idx_i == clr_idx_i))
        |=> (slot_q[$past(clr_idx_i)] == '0));

endmodule

// File: rtl/wbq_retire_queue.sv
module wbq_retire_queue #(
    parameter int DATA_W = 32,
    parameter int SLOTS  = 7,
    parameter int IDX_W  = 7,
    localparam int LAT_W = $clog2(SLOTS + 1),
    localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    input  logic [1:0]        cls_i,
    input  logic [DATA_W-1:0] result_i,
    input  logic [LAT_W-1:0]  lat_i,
    input  logic [IDX_W-1:0]  dest_i,
    output logic              rf_we_o,
    output logic [IDX_W-1:0]  rf_waddr_o,
    output logic [DATA_W-1:0] rf_wdata_o
);
    import wbq_pkg::*;

    step_cls_e         cls;
    logic              pop_step;
    logic              park_step;
    logic [PTR_W-1:0]  head;
    logic [PTR_W-1:0]  park_idx;
    logic [DATA_W-1:0] head_val;

    assign cls       = step_cls_e'(cls_i);
    assign pop_step  = step_i && (cls != CLS_VEC);
    assign park_step = step_i && cls_parks(cls);
    assign park_idx  = PTR_W'(ring_add(int'(head), int'(lat_i), SLOTS));

    wbq_head_ptr #(.SLOTS(SLOTS)) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .adv_i  (pop_step),
        .head_o (head)
    );

    wbq_slot_ring #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_ring (
        .clk        (clk),
        .rst        (rst),
        .rd_idx_i   (head),
        .rd_data_o  (head_val),
        .clr_en_i   (pop_step),
        .clr_idx_i  (head),
        .ins_en_i   (park_step),
        .ins_idx_i  (park_idx),
        .ins_data_i (result_i)
    );

    assign rf_we_o    = pop_step && (dest_i != '0);
    assign rf_waddr_o = dest_i;
    assign rf_wdata_o = head_val;

    a_r2_idle_no_write: assert property (@(posedge clk) disable iff (rst)
        !step_i |-> !rf_we_o);

    a_r4_zero_dest_no_write: assert property (@(posedge clk) disable iff (rst)
        (dest_i == '0) |-> !rf_we_o);

    a_r8_vec_no_write: assert property (@(posedge clk) disable iff (rst)
        (step_i && cls_i == 2'b10) |-> !rf_we_o);

    a_r6_park_in_range: assert property (@(posedge clk) disable iff (rst)
        park_step |-> (park_idx < PTR_W'(SLOTS)));

endmodule

// File: tb/tb_wbq_retire_queue.sv
module tb_wbq_retire_queue;
    localparam int CLK_P  = 10;
    localparam int DATA_W = 32;
    localparam int SLOTS  = 7;
    localparam int IDX_W  = 7;
    localparam int LAT_W  = $clog2(SLOTS + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              step_i = 1'b0;
    logic [1:0]        cls_i = 2'b00;
    logic [DATA_W-1:0] result_i = '0;
    logic [LAT_W-1:0]  lat_i = '0;
    logic [IDX_W-1:0]  dest_i = '0;
    logic              rf_we_o;
    logic [IDX_W-1:0]  rf_waddr_o;
    logic [DATA_W-1:0] rf_wdata_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 0;

    int unsigned mq [SLOTS];
    int          mhead;

    always #(CLK_P/2) clk = ~clk;

    wbq_retire_queue #(.DATA_W(DATA_W), .SLOTS(SLOTS), .IDX_W(IDX_W)) dut (
        .clk(clk), .rst(rst), .step_i(step_i), .cls_i(cls_i), .result_i(result_i),
        .lat_i(lat_i), .dest_i(dest_i), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
        .rf_wdata_o(rf_wdata_o)
    );

    task automatic model_reset();
        for (int i = 0; i < SLOTS; i++) mq[i] = 0;
        mhead = 0;
    endtask

    task automatic chk(string tag, bit ok, string what, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare before the next posedge, advance model.
    task automatic cyc(string tag, bit st, logic [1:0] c, int unsigned res, int lat, int dst);
        bit pops, exp_we;
        int old;
        @(negedge clk);
        step_i = st; cls_i = c; result_i = res; lat_i = LAT_W'(lat); dest_i = IDX_W'(dst);
        #(CLK_P/4);
        pops   = st && (c != 2'b10);
        exp_we = pops && (dst != 0);
        chk(tag, rf_we_o == exp_we, "we", rf_we_o, exp_we);
        if (exp_we) begin
            chk(tag, rf_waddr_o == IDX_W'(dst), "waddr", rf_waddr_o, dst);
            chk(tag, rf_wdata_o == mq[mhead], "wdata", rf_wdata_o, mq[mhead]);
        end
        if (pops) begin
            old = mhead;
            mq[old] = 0;
            mhead = (mhead + 1) % SLOTS;
            if (c == 2'b01 || c == 2'b11) mq[(old + lat) % SLOTS] = res;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; step_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        model_reset();
        do_reset();
        // R1: fresh reset, pops read zero
        for (int i = 0; i < SLOTS; i++) cyc("R1", 1, 2'b00, 0, 1, 5 + i);
        // fill slots, then reset again and confirm they are gone
        for (int i = 0; i < SLOTS; i++) cyc("R6", 1, 2'b01, 32'hA000 + i, SLOTS, 0);
        do_reset();
        for (int i = 0; i < SLOTS; i++) cyc("R1", 1, 2'b00, 0, 1, 9);
        // R6: different latencies retire in order of due step
        cyc("R6", 1, 2'b01, 32'h1111, 3, 0);
        cyc("R6", 1, 2'b11, 32'h2222, 1, 0);
        cyc("R6", 1, 2'b00, 0, 1, 12);
        cyc("R6", 1, 2'b00, 0, 1, 13);
        cyc("R6", 1, 2'b00, 0, 1, 14);
        // R2: idle cycles with live-looking inputs
        for (int i = 0; i < 4; i++) cyc("R2", 0, 2'b01, 32'hDEAD, 1, 33);
        cyc("R6", 1, 2'b01, 32'h3333, 2, 0);
        for (int i = 0; i < 3; i++) cyc("R2", 0, 2'b11, 32'hBEEF, 1, 40);
        cyc("R2", 1, 2'b00, 0, 1, 0);
        cyc("R2", 1, 2'b00, 0, 1, 20);
        // R8: vector steps freeze everything
        cyc("R8", 1, 2'b01, 32'h4444, 2, 0);
        cyc("R8", 1, 2'b10, 32'h5555, 1, 21);
        cyc("R8", 1, 2'b10, 32'h6666, 3, 22);
        cyc("R8", 1, 2'b00, 0, 1, 23);
        cyc("R8", 1, 2'b00, 0, 1, 24);
        // R4: zero destination drops the value yet still clears the slot
        cyc("R4", 1, 2'b01, 32'h7777, 1, 0);
        cyc("R4", 1, 2'b00, 0, 1, 0);
        for (int i = 0; i < SLOTS; i++) cyc("R4", 1, 2'b00, 0, 1, 25);
        // R9: collision, later park wins
        cyc("R9", 1, 2'b01, 32'h8888, 3, 0);
        cyc("R9", 1, 2'b01, 32'h9999, 2, 0);
        cyc("R9", 1, 2'b00, 0, 1, 26);
        cyc("R9", 1, 2'b00, 0, 1, 27);
        // R10: full latency and latency 0 land in the slot just cleared
        cyc("R10", 1, 2'b01, 32'hAAAA, SLOTS, 0);
        for (int i = 0; i < SLOTS; i++) cyc("R10", 1, 2'b00, 0, 1, 28);
        cyc("R10", 1, 2'b01, 32'hBBBB, 0, 0);
        for (int i = 0; i < SLOTS; i++) cyc("R10", 1, 2'b00, 0, 1, 29);
        // R7 / R5 / R3: no-op steps across many wraps with parks around them
        cyc("R7", 1, 2'b01, 32'hCCCC, 5, 0);
        cyc("R7", 1, 2'b00, 32'hFFFF, 2, 30);
        cyc("R7", 1, 2'b00, 32'hFFFF, 3, 31);
        for (int i = 0; i < 2 * SLOTS; i++) cyc("R5", 1, 2'b00, 0, 1, 1 + i);
        // R3: mixed random traffic compared every cycle
        for (int i = 0; i < 3000; i++) begin
            int unsigned r = $urandom;
            cyc("R3", r[0] | r[1], 2'(r[3:2]), $urandom, int'(r[6:4]), int'(r[13:7]) & 127);
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule